// File: doc/BRIEF.md
# Privileged Stack Pointer Fetch Unit

This block serves a privilege change. When the core switches to a more privileged level, it needs the stack pointer and stack selector for that level. These are stored in the task state segment that is currently loaded. On a request, the block takes the target level (0, 1 or 2), the task register selector and the cached descriptor fields (type, base, limit). It decides which segment layout applies, checks that the needed slot lies inside the limit, and then fetches the two values through a simple read port.

The block recognises two layouts. In the wide layout the pointer is a doubleword and the slots are 8 bytes apart. In the narrow layout the pointer is a word and the slots are 4 bytes apart. If the slot runs past the limit, the block reports a task-segment fault whose code is the selector with its two low bits cleared, and it issues no read. A descriptor type it does not accept, or a request for level 3, ends at once with an invalid-state error. Every outcome closes with a one-cycle `done` pulse. All results stay on the outputs until the next request is accepted.

Top module: `stk_ptr_fetch`

## Requirements
- R1: After reset `done`, `rd_req`, `fault_ts` and `bad_state` are 0, and `new_sp`, `new_ss` and `fault_code` are 0.
- R2: For `desc_type` 4'hB (busy, wide layout) and level L, the slot offset is 8*L+4. The pointer is read as a doubleword (`rd_dword`=1) at base+offset. The selector is then read as a word (`rd_dword`=0) at base+offset+4. Addresses wrap modulo 2^32.
- R3: For `desc_type` 4'h3 (busy, narrow layout) and level L, the slot offset is 4*L+2. The pointer is read as a word at base+offset, and only `rd_data[15:0]` is used, zero-extended to 32 bits. The selector is then read as a word at base+offset+2.
- R4: A limit fault occurs when offset+7 (wide) or offset+3 (narrow) is greater than `desc_limit`. When the two values are equal, the request passes.
- R5: When a request is accepted, `fault_code` takes `tr_sel` with bits 1:0 cleared. Whenever `fault_ts` is 1, `fault_code[1:0]` is 0.
- R6: On a limit fault no read is issued. `done` and `fault_ts` rise together in the cycle after the request is accepted.
- R7: If `desc_type` is neither 4'hB nor 4'h3, or if the level is 3, `bad_state` and `done` rise in the cycle after acceptance. In that case no read is issued and `fault_ts` stays 0.
- R8: The two reads are issued in order: the pointer first, then the selector. Each `rd_req` is a one-cycle pulse. The selector read is issued only after `rd_valid` has returned the pointer. `rd_valid` is ignored when no read is outstanding.
- R9: A request is accepted only when the block is idle, so `req_valid` while busy has no effect. `done` is a single-cycle pulse. On success it comes in the cycle after `rd_valid` returns the selector, and `new_sp` and `new_ss` update with it. All outputs hold their values until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request, taken when idle |
| req_level | input | 2 | Target privilege level |
| tr_sel | input | 16 | Task register selector |
| desc_type | input | 4 | Cached descriptor type code |
| desc_base | input | 32 | Cached segment base |
| desc_limit | input | 32 | Cached segment limit |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | 32 | Read byte address |
| rd_dword | output | 1 | 1 = doubleword read, 0 = word read |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| done | output | 1 | Completion pulse |
| fault_ts | output | 1 | Task-segment limit fault |
| bad_state | output | 1 | Invalid descriptor type or level |
| fault_code | output | 16 | Fault error code |
| new_sp | output | 32 | Fetched stack pointer |
| new_ss | output | 16 | Fetched stack selector |

## Verification
The assertions check the following on every cycle:
- `done` and `rd_req` are single-cycle pulses.
- A limit fault produces a fault with no read in the next cycle.
- The fault code always has its low bits clear.
- The two error flags are never set together.
- The selector read is always a word read.
- The results hold while the block is idle.

Only the bench scenarios can show the rest:
- the slot addresses for each layout and level, including base wraparound;
- the zero extension of the narrow pointer;
- the exact limit boundary;
- the pointer-before-selector order under different memory latencies;
- that a request made while busy is dropped.

// File: rtl/stkf_pkg.sv
package stkf_pkg;
  localparam int OFF_W  = 6;
  localparam int WORD_W = 16;
  localparam logic [3:0] TYPE_BUSY_WIDE   = 4'hB;
  localparam logic [3:0] TYPE_BUSY_NARROW = 4'h3;

  typedef enum logic [2:0] {
    S_IDLE, S_ISS_PTR, S_WAIT_PTR, S_ISS_SEL, S_WAIT_SEL
  } seq_e;

  // byte offset of the pointer slot for a level
  function automatic logic [OFF_W-1:0] slot_offset(input logic [1:0] lvl, input logic wide);
    return wide ? ((OFF_W'(lvl) << 3) + OFF_W'(4)) : ((OFF_W'(lvl) << 2) + OFF_W'(2));
  endfunction

  // last byte the slot touches
  function automatic logic [OFF_W-1:0] slot_last(input logic [OFF_W-1:0] off, input logic wide);
    return off + (wide ? OFF_W'(7) : OFF_W'(3));
  endfunction

  // distance from pointer to selector inside the slot
  function automatic logic [OFF_W-1:0] sel_gap(input logic wide);
    return wide ? OFF_W'(4) : OFF_W'(2);
  endfunction
endpackage

// File: rtl/stkf_layout.sv
module stkf_layout
  import stkf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 32,
  parameter int SEL_W  = 16
) (
  input  logic [1:0]        level,
  input  logic [3:0]        dtype,
  input  logic [ADDR_W-1:0] base,
  input  logic [LIM_W-1:0]  limit,
  input  logic [SEL_W-1:0]  tr_sel,
  output logic              wide,
  output logic              type_ok,
  output logic              lvl_ok,
  output logic              lim_fail,
  output logic [ADDR_W-1:0] ptr_addr,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [SEL_W-1:0]  err_code
);
  logic             narrow;
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] last;

  assign wide     = (dtype == TYPE_BUSY_WIDE);
  assign narrow   = (dtype == TYPE_BUSY_NARROW);
  assign type_ok  = wide | narrow;
  assign lvl_ok   = (level != 2'd3);
  assign off      = slot_offset(level, wide);
  assign last     = slot_last(off, wide);
  assign lim_fail = {{(LIM_W-OFF_W){1'b0}}, last} > limit;
  assign ptr_addr = base + {{(ADDR_W-OFF_W){1'b0}}, off};
  assign sel_addr = ptr_addr + {{(ADDR_W-OFF_W){1'b0}}, sel_gap(wide)};
  assign err_code = tr_sel & {{(SEL_W-2){1'b1}}, 2'b00};
endmodule

// File: rtl/stkf_seq.sv
module stkf_seq
  import stkf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              wide,
  input  logic              type_ok,
  input  logic              lvl_ok,
  input  logic              lim_fail,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic [SEL_W-1:0]  err_code,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_dword,
  output logic              done,
  output logic              fault_ts,
  output logic              bad_state,
  output logic [SEL_W-1:0]  fault_code,
  output logic [DATA_W-1:0] new_sp,
  output logic [SEL_W-1:0]  new_ss,
  output logic              accept_fault,
  output logic              rd_second,
  output logic              busy
);
  seq_e              state;
  logic              wide_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] sel_q;
  logic [DATA_W-1:0] sp_q;
  logic              accept;

  assign accept       = (state == S_IDLE) && req_valid;
  assign accept_fault = accept && type_ok && lvl_ok && lim_fail;
  assign rd_second    = (state == S_ISS_SEL);
  assign busy         = (state != S_IDLE);
  assign rd_req       = (state == S_ISS_PTR) || (state == S_ISS_SEL);
  assign rd_addr      = rd_second ? sel_q : ptr_q;
  assign rd_dword     = (state == S_ISS_PTR) && wide_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      wide_q     <= 1'b0;
      ptr_q      <= '0;
      sel_q      <= '0;
      sp_q       <= '0;
      done       <= 1'b0;
      fault_ts   <= 1'b0;
      bad_state  <= 1'b0;
      fault_code <= '0;
      new_sp     <= '0;
      new_ss     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          fault_code <= err_code;
          fault_ts   <= 1'b0;
          bad_state  <= 1'b0;
          wide_q     <= wide;
          ptr_q      <= ptr_addr;
          sel_q      <= sel_addr;
          if (!(type_ok && lvl_ok)) begin
            bad_state <= 1'b1;
            done      <= 1'b1;
          end else if (lim_fail) begin
            fault_ts <= 1'b1;
            done     <= 1'b1;
          end else begin
            state <= S_ISS_PTR;
          end
        end
        S_ISS_PTR: state <= S_WAIT_PTR;
        S_WAIT_PTR: if (rd_valid) begin
          sp_q  <= wide_q ? rd_data : {{(DATA_W-WORD_W){1'b0}}, rd_data[WORD_W-1:0]};
          state <= S_ISS_SEL;
        end
        S_ISS_SEL: state <= S_WAIT_SEL;
        S_WAIT_SEL: if (rd_valid) begin
          new_sp <= sp_q;
          new_ss <= rd_data[SEL_W-1:0];
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stk_ptr_fetch.sv
module stk_ptr_fetch #(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 32,
  parameter int SEL_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_level,
  input  logic [SEL_W-1:0]  tr_sel,
  input  logic [3:0]        desc_type,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [LIM_W-1:0]  desc_limit,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_dword,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              fault_ts,
  output logic              bad_state,
  output logic [SEL_W-1:0]  fault_code,
  output logic [DATA_W-1:0] new_sp,
  output logic [SEL_W-1:0]  new_ss
);
  logic              wide, type_ok, lvl_ok, lim_fail;
  logic [ADDR_W-1:0] ptr_addr, sel_addr;
  logic [SEL_W-1:0]  err_code;
  logic              accept_fault, rd_second, busy;

  stkf_layout #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .SEL_W(SEL_W)) u_layout (
    .level(req_level), .dtype(desc_type), .base(desc_base), .limit(desc_limit),
    .tr_sel(tr_sel), .wide(wide), .type_ok(type_ok), .lvl_ok(lvl_ok),
    .lim_fail(lim_fail), .ptr_addr(ptr_addr), .sel_addr(sel_addr), .err_code(err_code)
  );

  stkf_seq #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .wide(wide), .type_ok(type_ok),
    .lvl_ok(lvl_ok), .lim_fail(lim_fail), .ptr_addr(ptr_addr), .sel_addr(sel_addr),
    .err_code(err_code), .rd_valid(rd_valid), .rd_data(rd_data), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_dword(rd_dword), .done(done), .fault_ts(fault_ts),
    .bad_state(bad_state), .fault_code(fault_code), .new_sp(new_sp), .new_ss(new_ss),
    .accept_fault(accept_fault), .rd_second(rd_second), .busy(busy)
  );
endmodule

// File: rtl/stkf_chk.sv
module stkf_chk #(
  parameter int SEL_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rd_req,
  input logic              rd_dword,
  input logic              done,
  input logic              fault_ts,
  input logic              bad_state,
  input logic [SEL_W-1:0]  fault_code,
  input logic [DATA_W-1:0] new_sp,
  input logic [SEL_W-1:0]  new_ss,
  input logic              accept_fault,
  input logic              rd_second,
  input logic              busy
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_RDREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> !rd_req); // R8
  AST_FAULT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n) accept_fault |=> (done && fault_ts && !rd_req)); // R6
  AST_FAULT_CODE_MASK: assert property (@(posedge clk) disable iff (!rst_n) fault_ts |-> (fault_code[1:0] == 2'b00)); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(fault_ts && bad_state)); // R7
  AST_SEL_WORD_READ: assert property (@(posedge clk) disable iff (!rst_n) (rd_req && rd_second) |-> !rd_dword); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> ($stable(new_sp) && $stable(new_ss) && $stable(fault_code) && $stable(fault_ts))); // R9
endmodule

bind stk_ptr_fetch stkf_chk #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rd_req(rd_req), .rd_dword(rd_dword),
  .done(done), .fault_ts(fault_ts), .bad_state(bad_state), .fault_code(fault_code),
  .new_sp(new_sp), .new_ss(new_ss), .accept_fault(accept_fault),
  .rd_second(rd_second), .busy(busy)
);

// File: tb/stk_ptr_fetch_tb.sv
module stk_ptr_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_level = '0;
  logic [15:0] tr_sel = '0;
  logic [3:0]  desc_type = '0;
  logic [31:0] desc_base = '0;
  logic [31:0] desc_limit = '0;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        rd_req, rd_dword, done, fault_ts, bad_state;
  logic [31:0] rd_addr, new_sp;
  logic [15:0] fault_code, new_ss;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  stk_ptr_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level), .tr_sel(tr_sel),
    .desc_type(desc_type), .desc_base(desc_base), .desc_limit(desc_limit),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_dword(rd_dword), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .fault_ts(fault_ts), .bad_state(bad_state),
    .fault_code(fault_code), .new_sp(new_sp), .new_ss(new_ss)
  );

  function automatic logic [15:0] memw(input logic [31:0] a);
    return (a[15:0] * 16'h9E37) ^ a[31:16] ^ 16'h5A5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference, updated on each rising edge
  int          m_st = 0;        // 0 idle, 1 ptr issue, 2 ptr wait, 3 sel issue, 4 sel wait
  bit          m_wide, m_done, m_ft, m_bad;
  logic [31:0] m_ptr, m_sel, m_tmp, m_sp;
  logic [15:0] m_code, m_ss;
  string       m_tag = "R2";
  longint      off_l, last_l;
  bit          w_l, n_l;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= 0; m_done <= 0; m_ft <= 0; m_bad <= 0; m_sp <= 0; m_ss <= 0; m_code <= 0;
      m_ptr <= 0; m_sel <= 0; m_wide <= 0;
    end else begin
      m_done <= 0;
      if (m_st == 0) begin
        if (req_valid) begin
          w_l = (desc_type == 4'hB);
          n_l = (desc_type == 4'h3);
          m_code <= tr_sel & 16'hFFFC;
          m_ft <= 0; m_bad <= 0;
          if (!(w_l || n_l) || req_level == 2'd3) begin
            m_bad <= 1; m_done <= 1;
          end else begin
            off_l  = w_l ? 4 + 8 * longint'(req_level) : 2 + 4 * longint'(req_level);
            last_l = off_l + (w_l ? 7 : 3);
            if (last_l > longint'(desc_limit)) begin
              m_ft <= 1; m_done <= 1;
            end else begin
              m_st   <= 1;
              m_wide <= w_l;
              m_tag  <= w_l ? "R2" : "R3";
              m_ptr  <= desc_base + 32'(off_l);
              m_sel  <= desc_base + 32'(off_l) + (w_l ? 32'd4 : 32'd2);
            end
          end
        end
      end else if (m_st == 1) m_st <= 2;
      else if (m_st == 2) begin
        if (rd_valid) begin
          m_tmp <= m_wide ? rd_data : (rd_data & 32'h0000FFFF);
          m_st  <= 3;
        end
      end else if (m_st == 3) m_st <= 4;
      else if (rd_valid) begin
        m_sp <= m_tmp; m_ss <= rd_data[15:0]; m_done <= 1; m_st <= 0;
      end
    end
  end

  // per-cycle comparison, then the memory responder
  int          mem_lat = 1;
  int          pend = 0;
  logic [31:0] pend_a;
  bit          pend_dw;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(done === m_done, "R9", "done", 32'(done), 32'(m_done));
      chk(rd_req === (m_st == 1 || m_st == 3), "R8", "rd_req", 32'(rd_req), 32'(m_st == 1 || m_st == 3));
      if (m_st == 1) begin
        chk(rd_addr === m_ptr, m_tag, "pointer address", rd_addr, m_ptr);
        chk(rd_dword === m_wide, m_tag, "pointer size", 32'(rd_dword), 32'(m_wide));
      end
      if (m_st == 3) begin
        chk(rd_addr === m_sel, m_tag, "selector address", rd_addr, m_sel);
        chk(rd_dword === 1'b0, m_tag, "selector size", 32'(rd_dword), 32'd0);
      end
      chk(fault_ts === m_ft, "R6", "fault_ts", 32'(fault_ts), 32'(m_ft));
      chk(bad_state === m_bad, "R7", "bad_state", 32'(bad_state), 32'(m_bad));
      chk(fault_code === m_code, "R5", "fault_code", 32'(fault_code), 32'(m_code));
      chk(new_sp === m_sp, "R9", "new_sp", new_sp, m_sp);
      chk(new_ss === m_ss, "R9", "new_ss", 32'(new_ss), 32'(m_ss));
    end
    rd_valid = 1'b0;
    rd_data  = 32'hBAD0_BAD0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        rd_valid = 1'b1;
        rd_data  = pend_dw ? {memw(pend_a + 32'd2), memw(pend_a)} : {16'hEE11 ^ pend_a[15:0], memw(pend_a)};
      end
    end
    if (rd_req && rst_n) begin
      pend = mem_lat; pend_a = rd_addr; pend_dw = rd_dword;
    end
  end

  task automatic start_req(input logic [1:0] lvl, input logic [3:0] ty, input logic [31:0] base,
                           input logic [31:0] lim, input logic [15:0] sel);
    @(negedge clk);
    req_level = lvl; desc_type = ty; desc_base = base; desc_limit = lim; tr_sel = sel;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    bit seen = 0;
    for (int k = 0; k < 80; k++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, tag, "done seen", 32'(seen), 32'd1);
  endtask

  task automatic run_ok(input logic [1:0] lvl, input logic [3:0] ty, input logic [31:0] base,
                        input logic [31:0] lim, input int lat, input string tag);
    logic [31:0] a, esp;
    logic [15:0] ess;
    mem_lat = lat;
    a   = (ty == 4'hB) ? base + 32'(lvl) * 8 + 4 : base + 32'(lvl) * 4 + 2;
    esp = (ty == 4'hB) ? {memw(a + 2), memw(a)} : {16'h0, memw(a)};
    ess = (ty == 4'hB) ? memw(a + 4) : memw(a + 2);
    start_req(lvl, ty, base, lim, 16'h0043);
    wait_done(tag);
    chk(!fault_ts && !bad_state, tag, "no error flag", {fault_ts, bad_state}, 32'd0);
    chk(new_sp === esp, tag, "stack pointer value", new_sp, esp);
    chk(new_ss === ess, tag, "stack selector value", 32'(new_ss), 32'(ess));
    @(negedge clk);
  endtask

  task automatic run_fault(input logic [1:0] lvl, input logic [3:0] ty, input logic [31:0] lim,
                           input logic [15:0] sel, input bit expect_bad, input string tag);
    start_req(lvl, ty, 32'h0000_4000, lim, sel);
    chk(done === 1'b1, tag, "done one cycle after accept", 32'(done), 32'd1);
    chk(rd_req === 1'b0, tag, "no read issued", 32'(rd_req), 32'd0);
    chk(fault_ts === !expect_bad, tag, "fault_ts", 32'(fault_ts), 32'(!expect_bad));
    chk(bad_state === expect_bad, tag, "bad_state", 32'(bad_state), 32'(expect_bad));
    chk(fault_code === (sel & 16'hFFFC), "R5", "error code", 32'(fault_code), 32'(sel & 16'hFFFC));
    @(negedge clk);
    chk(done === 1'b0, "R9", "done single pulse", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!done && !rd_req && !fault_ts && !bad_state, "R1", "reset flags",
        {done, rd_req, fault_ts, bad_state}, 32'd0);
    chk(new_sp == 0 && new_ss == 0 && fault_code == 0, "R1", "reset values", new_sp, 32'd0);

    run_ok(2'd0, 4'hB, 32'h0000_1000, 32'h67, 1, "R2");
    run_ok(2'd2, 4'hB, 32'hFFFF_FFF0, 32'h67, 3, "R2");   // wrap of base+offset
    run_ok(2'd1, 4'h3, 32'h0000_2000, 32'h2B, 2, "R3");   // upper read bits dropped
    run_ok(2'd2, 4'h3, 32'h0000_3000, 32'd13, 1, "R4");   // last byte equals limit
    run_ok(2'd1, 4'hB, 32'h0000_5000, 32'd19, 4, "R4");   // last byte equals limit
    run_fault(2'd2, 4'h3, 32'd12, 16'h1237, 1'b0, "R4");
    run_fault(2'd1, 4'hB, 32'd18, 16'h00FF, 1'b0, "R6");
    run_fault(2'd0, 4'h9, 32'hFFFF, 16'h0011, 1'b1, "R7");
    run_fault(2'd3, 4'hB, 32'hFFFF, 16'h0022, 1'b1, "R7");

    // R9: request held while busy is dropped; first result must survive
    mem_lat = 4;
    @(negedge clk);
    req_level = 2'd1; desc_type = 4'hB; desc_base = 32'h0000_6000; desc_limit = 32'h67;
    tr_sel = 16'h0008; req_valid = 1'b1;
    @(negedge clk);
    desc_type = 4'h9; req_level = 2'd3;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R9");
    chk(!bad_state, "R9", "busy request ignored", 32'(bad_state), 32'd0);
    chk(new_sp === {memw(32'h600E), memw(32'h600C)}, "R9", "result of first request", new_sp,
        {memw(32'h600E), memw(32'h600C)});
    repeat (5) @(negedge clk);
    chk(new_ss === memw(32'h6010), "R9", "outputs held while idle", 32'(new_ss), 32'(memw(32'h6010)));

    // R8: stray rd_valid while idle has no effect
    @(negedge clk);
    pend = 1; pend_a = 32'h0; pend_dw = 1'b1;
    repeat (3) @(negedge clk);
    chk(!done && new_ss === memw(32'h6010), "R8", "stray rd_valid ignored", 32'(new_ss), 32'(memw(32'h6010)));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule